// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the running time of day for a precision time protocol clock. The time is a seconds count and a nanoseconds count. On every clock edge it advances by a programmable step. That step has an integer nanoseconds part and a 24-bit fraction of a nanosecond. A fraction accumulator turns the fractional part into an occasional extra nanosecond, so the long-run rate can be tuned far more finely than one nanosecond per clock. The seconds and nanoseconds are driven out as ports for timestamping logic. A one-cycle pulse marks each moment at which the seconds count advances.

Software reaches the counter through a simple write port and a live read port. It can load the nanoseconds, and it can load the seconds in two halves, where the high half waits until the low half is written. It can also apply a signed one-shot step to the time. A frequency correction is written as a fraction that waits in a shadow register until the integer part is written. This lets the two halves of the increment switch over together.

Top module: `ptp_tod_counter`

## Requirements
- R1: On a clock edge with no time write, nanoseconds advance by the active integer increment, plus 1 when the 24-bit fraction accumulator (accumulator + active fraction) carries out; the accumulator runs on every edge, including edges with a time write.
- R2: When the advanced nanoseconds reach NS_WRAP they wrap modulo NS_WRAP and seconds increase by one. `pps` is high for exactly the cycle in which the new seconds value first appears, and only on a forward carry.
- R3: A write to address 2 (seconds high) is only held pending: the time and the live read of address 2 are unchanged. A write to address 1 (seconds low) loads seconds = {pending high, data}, and nanoseconds do not advance on that edge.
- R4: A write to address 0 loads nanoseconds from the data, saturating at NS_WRAP-1. Seconds are unchanged, and no increment is added on that edge.
- R5: In the fraction register (address 4), data bits [15:0] hold fraction bits [23:8] and data bits [31:24] hold fraction bits [7:0]. A write to it is staged. Only a write to address 3 (integer increment, data bits [NS_INT_W-1:0]) makes the staged fraction active, together with the new integer part. A read of address 4 returns the active fraction in the same layout.
- R6: A write to address 5 applies a one-shot step instead of that edge's increment. Data bit 31 set means subtract. The magnitude is bits [29:0], saturated to NS_WRAP-1. A result below zero borrows one second without a `pps` pulse. A result at or above NS_WRAP carries one second with a `pps` pulse.
- R7: After reset, seconds, nanoseconds, both increments and `pps` are zero. While both active increments are zero, the time does not move.
- R8: Reads are live and combinational: address 0 gives nanoseconds, address 1 gives seconds bits [31:0], and address 2 gives the seconds bits above 31. Reading nanoseconds, then seconds, then nanoseconds lets a rollover be detected and resolved by re-reading seconds.
- R9: Reads of address 3 return the active integer increment. Reads of address 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Live read data for rd_addr |
| tod_sec | output | 32+SEC_HI_W | Current seconds |
| tod_ns | output | clog2(NS_WRAP) | Current nanoseconds |
| pps | output | 1 | One-cycle pulse on each forward seconds carry |

## Verification
The bench builds the counter with NS_WRAP = 1000, SEC_HI_W = 8, NS_INT_W = 8 and the fraction path enabled. With a one-thousand-count wrap, a second passes every few hundred cycles. Many `pps` pulses, forward carries and borrows from adjust steps, and the saturation of out-of-range loads all fall within a short run. A cycle model in the bench follows every edge of a long random mix of writes, including edges where the fraction accumulator carries while a time write drops the increment.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

   localparam int FRAC_W = 24;
   localparam int ADJ_MAG_W = 30;
   localparam int ADJ_SIGN_BIT = 31;

   typedef enum logic [2:0] {
      TOD_NS      = 3'd0,
      TOD_SEC_LO  = 3'd1,
      TOD_SEC_HI  = 3'd2,
      TOD_INC_INT = 3'd3,
      TOD_INC_FRC = 3'd4,
      TOD_ADJUST  = 3'd5
   } tod_reg_e;

   function automatic logic [31:0] frac_to_word(logic [FRAC_W-1:0] f);
      return {f[7:0], 8'h00, f[23:8]};
   endfunction

   function automatic logic [FRAC_W-1:0] word_to_frac(logic [31:0] w);
      return {w[15:0], w[31:24]};
   endfunction

endpackage

// File: rtl/ptp_tod_regfile.sv
module ptp_tod_regfile
   import ptp_tod_pkg::*;
#(
   parameter int SEC_HI_W = 16,
   parameter int NS_INT_W = 8,
   parameter bit FRAC_EN  = 1'b1,
   localparam int SEC_W   = 32 + SEC_HI_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           wr_addr,
   input  logic [31:0]          wr_data,
   output logic                 ld_ns,
   output logic                 ld_sec,
   output logic                 ld_adj,
   output logic [SEC_W-1:0]     sec_commit,
   output logic [NS_INT_W-1:0]  act_int,
   output logic [FRAC_W-1:0]    act_frac
);

   tod_reg_e            sel;
   logic [SEC_HI_W-1:0] pend_hi;
   logic                wr_int;

   assign sel        = tod_reg_e'(wr_addr);
   assign ld_ns      = wr_en && (sel == TOD_NS);
   assign ld_sec     = wr_en && (sel == TOD_SEC_LO);
   assign ld_adj     = wr_en && (sel == TOD_ADJUST);
   assign wr_int     = wr_en && (sel == TOD_INC_INT);
   assign sec_commit = {pend_hi, wr_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_hi <= '0;
         act_int <= '0;
      end else begin
         if (wr_en && (sel == TOD_SEC_HI)) pend_hi <= wr_data[SEC_HI_W-1:0];
         if (wr_int)                       act_int <= wr_data[NS_INT_W-1:0];
      end
   end

   generate
      if (FRAC_EN) begin : g_frac
         logic [FRAC_W-1:0] shadow;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow   <= '0;
               act_frac <= '0;
            end else begin
               if (wr_en && (sel == TOD_INC_FRC)) shadow <= word_to_frac(wr_data);
               if (wr_int)                        act_frac <= shadow;
            end
         end
      end else begin : g_nofrac
         assign act_frac = '0;
      end
   endgenerate

   // R5: the active fraction moves only on an integer-increment write
   a_r5_frac_staged: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_int |=> $stable(act_frac));

endmodule

// File: rtl/ptp_tod_step.sv
module ptp_tod_step
   import ptp_tod_pkg::*;
#(
   parameter int NS_INT_W = 8,
   parameter bit FRAC_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NS_INT_W-1:0] inc_int,
   input  logic [FRAC_W-1:0]   inc_frac,
   output logic [NS_INT_W:0]   step
);

   generate
      if (FRAC_EN) begin : g_acc
         logic [FRAC_W-1:0] acc;
         logic [FRAC_W:0]   acc_sum;
         assign acc_sum = {1'b0, acc} + {1'b0, inc_frac};
         assign step    = {1'b0, inc_int} + {{NS_INT_W{1'b0}}, acc_sum[FRAC_W]};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) acc <= '0;
            else        acc <= acc_sum[FRAC_W-1:0];
         end
      end else begin : g_int_only
         assign step = {1'b0, inc_int};
      end
   endgenerate

endmodule

// File: rtl/ptp_tod_time.sv
module ptp_tod_time
   import ptp_tod_pkg::*;
#(
   parameter int NS_WRAP  = 1_000_000_000,
   parameter int SEC_W    = 48,
   parameter int NS_INT_W = 8,
   localparam int NS_W    = $clog2(NS_WRAP),
   localparam int SUM_W   = NS_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_ns,
   input  logic                ld_sec,
   input  logic                ld_adj,
   input  logic [31:0]         wr_data,
   input  logic [SEC_W-1:0]    sec_commit,
   input  logic [NS_INT_W:0]   step,
   output logic [NS_W-1:0]     ns,
   output logic [SEC_W-1:0]    sec,
   output logic                pps
);

   localparam logic [31:0]      WRAP32 = 32'(NS_WRAP);
   localparam logic [NS_W-1:0]  NS_MAX = NS_W'(NS_WRAP - 1);
   localparam logic [SUM_W-1:0] WRAP_S = SUM_W'(NS_WRAP);

   logic [NS_W-1:0]  ns_load, mag, ns_n;
   logic [SEC_W-1:0] sec_n;
   logic [SUM_W-1:0] delta, sum;
   logic             carry_up, borrow;

   assign ns_load = (wr_data >= WRAP32) ? NS_MAX : wr_data[NS_W-1:0];
   assign mag     = ({2'b00, wr_data[ADJ_MAG_W-1:0]} >= WRAP32) ? NS_MAX
                    : wr_data[NS_W-1:0];

   always_comb begin
      if (ld_adj) begin
         delta = wr_data[ADJ_SIGN_BIT] ? (~{2'b00, mag} + SUM_W'(1)) : {2'b00, mag};
      end else begin
         delta = SUM_W'(step);
      end
      sum      = {2'b00, ns} + delta;
      carry_up = 1'b0;
      borrow   = 1'b0;
      ns_n     = ns;
      sec_n    = sec;
      if (ld_ns) begin
         ns_n = ns_load;
      end else if (ld_sec) begin
         sec_n = sec_commit;
      end else if (sum[SUM_W-1]) begin
         ns_n   = NS_W'(sum + WRAP_S);
         sec_n  = sec - SEC_W'(1);
         borrow = 1'b1;
      end else if (sum >= WRAP_S) begin
         ns_n     = NS_W'(sum - WRAP_S);
         sec_n    = sec + SEC_W'(1);
         carry_up = 1'b1;
      end else begin
         ns_n = sum[NS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns  <= '0;
         sec <= '0;
         pps <= 1'b0;
      end else begin
         ns  <= ns_n;
         sec <= sec_n;
         pps <= carry_up;
      end
   end

   // R2: nanoseconds stay inside one second
   a_r2_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
      ns <= NS_MAX);

   // R2: a pulse always comes with seconds one above the previous value
   a_r2_pps_step: assert property (@(posedge clk) disable iff (!rst_n)
      carry_up |=> pps && (sec == $past(sec) + SEC_W'(1)));

   // R6: a borrow steps seconds down and raises no pulse
   a_r6_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      borrow |=> !pps && (sec == $past(sec) - SEC_W'(1)));

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int NS_WRAP  = 1_000_000_000,
   parameter int SEC_HI_W = 16,
   parameter int NS_INT_W = 8,
   parameter bit FRAC_EN  = 1'b1,
   localparam int NS_W    = $clog2(NS_WRAP),
   localparam int SEC_W   = 32 + SEC_HI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       rd_addr,
   output logic [31:0]      rd_data,
   output logic [SEC_W-1:0] tod_sec,
   output logic [NS_W-1:0]  tod_ns,
   output logic             pps
);

   generate
      if (NS_WRAP < 2 || NS_WRAP > (1 << 30)) begin : g_bad_wrap
         $error("NS_WRAP out of range");
      end
      if (SEC_HI_W < 1 || SEC_HI_W > 32) begin : g_bad_sec
         $error("SEC_HI_W out of range");
      end
      if (NS_INT_W < 1 || NS_INT_W > 24 || (1 << NS_INT_W) > NS_WRAP) begin : g_bad_inc
         $error("NS_INT_W too wide for NS_WRAP");
      end
   endgenerate

   logic                ld_ns, ld_sec, ld_adj;
   logic [SEC_W-1:0]    sec_commit;
   logic [NS_INT_W-1:0] act_int;
   logic [FRAC_W-1:0]   act_frac;
   logic [NS_INT_W:0]   step;

   ptp_tod_regfile #(
      .SEC_HI_W (SEC_HI_W),
      .NS_INT_W (NS_INT_W),
      .FRAC_EN  (FRAC_EN)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .ld_ns      (ld_ns),
      .ld_sec     (ld_sec),
      .ld_adj     (ld_adj),
      .sec_commit (sec_commit),
      .act_int    (act_int),
      .act_frac   (act_frac)
   );

   ptp_tod_step #(
      .NS_INT_W (NS_INT_W),
      .FRAC_EN  (FRAC_EN)
   ) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_int  (act_int),
      .inc_frac (act_frac),
      .step     (step)
   );

   ptp_tod_time #(
      .NS_WRAP  (NS_WRAP),
      .SEC_W    (SEC_W),
      .NS_INT_W (NS_INT_W)
   ) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_ns      (ld_ns),
      .ld_sec     (ld_sec),
      .ld_adj     (ld_adj),
      .wr_data    (wr_data),
      .sec_commit (sec_commit),
      .step       (step),
      .ns         (tod_ns),
      .sec        (tod_sec),
      .pps        (pps)
   );

   always_comb begin
      case (tod_reg_e'(rd_addr))
         TOD_NS:      rd_data = 32'(tod_ns);
         TOD_SEC_LO:  rd_data = tod_sec[31:0];
         TOD_SEC_HI:  rd_data = 32'(tod_sec[SEC_W-1:32]);
         TOD_INC_INT: rd_data = 32'(act_int);
         TOD_INC_FRC: rd_data = frac_to_word(act_frac);
         default:     rd_data = 32'h0;
      endcase
   end

   // R3: a seconds-high write alone moves seconds only by a normal carry
   a_r3_hi_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd2) |=> (tod_sec == $past(tod_sec)) || pps);

   // R7: with both increments zero and no write, time is frozen
   a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (act_int == '0 && act_frac == '0 && !wr_en) |=> $stable(tod_ns) && $stable(tod_sec));

endmodule

// File: tb/ptp_tod_counter_bench.sv
module ptp_tod_counter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WRAP  = 1000;
   localparam int HI_W  = 8;
   localparam int INT_W = 8;
   localparam int NSW   = $clog2(WRAP);
   localparam int SW    = 32 + HI_W;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_addr = '0;
   logic [31:0]    wr_data = '0;
   logic [2:0]     rd_addr = '0;
   logic [31:0]    rd_data;
   logic [SW-1:0]  tod_sec;
   logic [NSW-1:0] tod_ns;
   logic           pps;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // bench model of the counter
   logic [SW-1:0]    m_sec;
   int               m_ns;
   logic             m_pps;
   logic [23:0]      m_acc, m_frac, m_shadow;
   logic [INT_W-1:0] m_int;
   logic [HI_W-1:0]  m_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptp_tod_counter #(
      .NS_WRAP  (WRAP),
      .SEC_HI_W (HI_W),
      .NS_INT_W (INT_W),
      .FRAC_EN  (1'b1)
   ) u_ptp_tod_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .tod_sec (tod_sec),
      .tod_ns  (tod_ns),
      .pps     (pps)
   );

   function automatic logic [31:0] pack_f(logic [23:0] f);
      return {f[7:0], 8'h00, f[23:8]};
   endfunction

   function automatic logic [23:0] unpack_f(logic [31:0] w);
      return {w[15:0], w[31:24]};
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_edge(bit we, logic [2:0] a, logic [31:0] d);
      logic [24:0] s;
      int st, v, mag;
      s = {1'b0, m_acc} + {1'b0, m_frac};
      st = int'(m_int) + int'(s[24]);
      m_acc = s[23:0];
      m_pps = 1'b0;
      if (we && a == 3'd0) begin
         m_ns = (d >= 32'(WRAP)) ? WRAP - 1 : int'(d);
      end else if (we && a == 3'd1) begin
         m_sec = {m_pend, d};
      end else begin
         if (we && a == 3'd5) begin
            mag = (d[29:0] >= 30'(WRAP)) ? WRAP - 1 : int'(d[29:0]);
            v = d[31] ? m_ns - mag : m_ns + mag;
         end else begin
            v = m_ns + st;
         end
         if (v < 0) begin
            m_ns = v + WRAP; m_sec = m_sec - 1;
         end else if (v >= WRAP) begin
            m_ns = v - WRAP; m_sec = m_sec + 1; m_pps = 1'b1;
         end else begin
            m_ns = v;
         end
      end
      if (we && a == 3'd2) m_pend = d[HI_W-1:0];
      if (we && a == 3'd4) m_shadow = unpack_f(d);
      if (we && a == 3'd3) begin
         m_int = d[INT_W-1:0];
         m_frac = m_shadow;
      end
   endtask

   // one clock: drive at the falling edge, compare at the next falling edge
   task automatic tick(bit we, logic [2:0] a, logic [31:0] d);
      wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_edge(we, a, d);
      @(negedge clk);
      wr_en = 1'b0;
      check("R1 time ns", 64'(tod_ns), 64'(m_ns));
      check("R1 time sec", 64'(tod_sec), 64'(m_sec));
      check("R2 pps", 64'(pps), 64'(m_pps));
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, first, second, s0, s1;
      void'($urandom(32'd1588));
      m_sec = '0; m_ns = 0; m_pps = 1'b0; m_acc = '0; m_frac = '0;
      m_shadow = '0; m_int = '0; m_pend = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state and standstill
      check("R7 reset ns", 64'(tod_ns), 64'd0);
      check("R7 reset sec", 64'(tod_sec), 64'd0);
      check("R7 reset pps", 64'(pps), 64'd0);
      rd(3'd3, r); check("R7 reset int", 64'(r), 64'd0);
      rd(3'd4, r); check("R7 reset frac", 64'(r), 64'd0);
      repeat (20) tick(1'b0, 3'd0, 32'h0);
      check("R7 frozen ns", 64'(tod_ns), 64'd0);

      // R5: staged fraction, packed layout
      tick(1'b1, 3'd4, pack_f(24'h80_0001));
      rd(3'd4, r); check("R5 staged frac not active", 64'(r), 64'd0);
      tick(1'b0, 3'd0, 32'h0);
      check("R5 no motion before int write", 64'(tod_ns), 64'd0);
      tick(1'b1, 3'd3, 32'd3);
      rd(3'd4, r); check("R5 frac active", 64'(r), 64'(pack_f(24'h80_0001)));
      rd(3'd3, r); check("R9 int readback", 64'(r), 64'd3);
      repeat (10) tick(1'b0, 3'd0, 32'h0);

      // R3: pending high half
      s0 = 32'(tod_sec[31:0]);
      tick(1'b1, 3'd2, 32'h5A);
      rd(3'd2, r); check("R3 live high unchanged", 64'(r), 64'd0);
      check("R3 sec unchanged by high write", 64'(tod_sec), 64'(s0));
      tick(1'b1, 3'd1, 32'h1234_5678);
      check("R3 sec commit", 64'(tod_sec), 64'h5A_1234_5678);
      rd(3'd2, r); check("R3 live high after commit", 64'(r), 64'h5A);

      // R4: nanoseconds load and saturation
      tick(1'b1, 3'd0, 32'd990);
      check("R4 ns load", 64'(tod_ns), 64'd990);
      tick(1'b1, 3'd0, 32'd5000);
      check("R4 ns saturate", 64'(tod_ns), 64'(WRAP - 1));

      // R2: rollover and pulse
      s1 = 32'(tod_sec[31:0]);
      tick(1'b0, 3'd0, 32'h0);
      check("R2 pps on rollover", 64'(pps), 64'd1);
      check("R2 sec carried", 64'(tod_sec[31:0]), 64'(s1 + 1));
      tick(1'b0, 3'd0, 32'h0);
      check("R2 pps one cycle", 64'(pps), 64'd0);

      // R6: borrow, forward carry, saturated magnitude
      tick(1'b1, 3'd0, 32'd10);
      s1 = 32'(tod_sec[31:0]);
      tick(1'b1, 3'd5, 32'h8000_0000 | 32'd50);
      check("R6 borrow ns", 64'(tod_ns), 64'd960);
      check("R6 borrow sec", 64'(tod_sec[31:0]), 64'(s1 - 1));
      check("R6 no pps on borrow", 64'(pps), 64'd0);
      tick(1'b1, 3'd5, 32'd100);
      check("R6 forward carry pps", 64'(pps), 64'd1);
      check("R6 forward carry ns", 64'(tod_ns), 64'd60);
      tick(1'b1, 3'd5, 32'd30000);
      check("R6 magnitude saturates", 64'(tod_ns), 64'd59);
      rd(3'd5, r); check("R9 adjust reads zero", 64'(r), 64'd0);
      rd(3'd6, r); check("R9 addr6 zero", 64'(r), 64'd0);
      rd(3'd7, r); check("R9 addr7 zero", 64'(r), 64'd0);

      // R8: live reads around a rollover
      tick(1'b1, 3'd4, 32'h0);
      tick(1'b1, 3'd3, 32'd2);
      tick(1'b1, 3'd0, 32'd996);
      rd(3'd0, first);
      check("R8 read ns live", 64'(first), 64'd996);
      tick(1'b0, 3'd0, 32'h0);
      rd(3'd1, s0);
      tick(1'b0, 3'd0, 32'h0);
      rd(3'd0, second);
      check("R8 rollover detected", 64'(second < first), 64'd1);
      rd(3'd1, s1);
      check("R8 reread sec", 64'(s1), 64'(s0 + 1));
      check("R8 reconciled sec", 64'(s1), 64'(m_sec[31:0]));

      // R7: both increments zero stops
      tick(1'b1, 3'd3, 32'd0);
      s0 = 32'(tod_ns);
      repeat (8) tick(1'b0, 3'd0, 32'h0);
      check("R7 stopped", 64'(tod_ns), 64'(s0));

      // R1..R6: constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int sel;
         sel = int'($urandom_range(0, 99));
         if (sel < 80)      tick(1'b0, 3'd0, 32'h0);
         else if (sel < 83) tick(1'b1, 3'd0, 32'($urandom_range(0, 1100)));
         else if (sel < 85) tick(1'b1, 3'd1, $urandom);
         else if (sel < 87) tick(1'b1, 3'd2, $urandom);
         else if (sel < 90) tick(1'b1, 3'd3, 32'($urandom_range(0, 255)));
         else if (sel < 94) tick(1'b1, 3'd4, $urandom);
         else if (sel < 97) tick(1'b1, 3'd5, {$urandom_range(0, 1) == 1, 31'($urandom_range(0, 1200))});
         else               tick(1'b1, 3'($urandom_range(6, 7)), $urandom);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule